// File: doc/BRIEF.md
# Eviction Drain Buffer with Miss-Load Forwarding

This block is a small first-in first-out store that sits between a level-one cache and the next memory level. The cache hands it dirty lines that are being evicted and single write-through stores. It accepts each one as soon as a slot is free, without waiting for the next level. In the background it streams the entries to the next level, oldest first.

Data that has left the cache but has not yet reached memory must still be visible to the processor. For that reason, any load that misses the cache presents its line address on a lookup port in the same cycle. The block answers combinationally from every entry it holds. Each byte is taken from the youngest entry that matches the address and has that byte valid. A mask reports which bytes were supplied. The cache uses those bytes in place of the stale copy from the next level.

Byte b of a line occupies data bits [8b+7:8b] and is qualified by mask bit b. Entries hold one line address, one line of data and one byte mask each. DEPTH must be a power of two, at least 2.

Top module: `evict_drain_buffer`

## Requirements
- R1: While reset is low, and in the first cycle after it, the buffer is empty: `drn_valid` is 0, `enq_ready` is 1 and `lkp_hit` is 0. Reset clears all held entries at once.
- R2: An entry is accepted on a rising edge where `enq_valid` and `enq_ready` are both 1. If the buffer was empty, that entry is presented on the drain port from the next cycle.
- R3: When DEPTH entries are held, `enq_ready` is 0. An `enq_valid` pulse in such a cycle stores nothing, even if a drain happens in the same cycle.
- R4: The drain port presents entries in acceptance order. An entry leaves only on an edge with `drn_valid` and `drn_ready` both 1. While `drn_ready` is 0, the presented address, data and mask stay unchanged.
- R5: With `lkp_valid` at 1, `lkp_hit` is 1 exactly when some held entry has an address equal to `lkp_addr` and a non-zero mask. With `lkp_valid` at 0, or on a miss, `lkp_hit` is 0 and `lkp_mask` and `lkp_data` are all zero.
- R6: On a hit, bit b of `lkp_mask` is the OR of mask bit b over all matching entries. Byte b of `lkp_data` comes from the youngest matching entry whose mask bit b is 1. Bytes with mask bit 0 read as zero.
- R7: A lookup in the same cycle as the drain of a matching entry still returns that entry's bytes.
- R8: A lookup sees only entries held before the current edge. An entry being accepted in the same cycle is not yet visible.
- R9: An enqueue and a drain on the same edge, with the buffer not full, keep the occupancy unchanged and keep both orderings intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Cache offers an evicted line or write-through store |
| enq_ready | output | 1 | A free slot exists |
| enq_addr | input | ADDR_W | Line address of the offered entry |
| enq_data | input | 8*LINE_BYTES | Line data |
| enq_mask | input | LINE_BYTES | Byte valid mask |
| drn_valid | output | 1 | Oldest entry is presented to the next level |
| drn_ready | input | 1 | Next level takes the presented entry |
| drn_addr | output | ADDR_W | Line address of the oldest entry |
| drn_data | output | 8*LINE_BYTES | Data of the oldest entry |
| drn_mask | output | LINE_BYTES | Byte mask of the oldest entry |
| lkp_valid | input | 1 | A cache-miss load is searching |
| lkp_addr | input | ADDR_W | Line address of the load |
| lkp_hit | output | 1 | At least one byte is supplied |
| lkp_data | output | 8*LINE_BYTES | Merged bytes, youngest wins |
| lkp_mask | output | LINE_BYTES | Bytes supplied by the buffer |

## Verification
The lookup is tried with a full-line entry alone, which shows that a plain match is found. Two partial entries for one line whose masks overlap on one byte show that the youngest entry wins only on the shared byte and that the other bytes merge. Addresses held by no entry, and addresses just drained, tell a real match apart from a left-over slot. Lookups issued in the cycle their entry drains or is accepted separate the pre-edge and post-edge views. Drain order, holding under backpressure, refusal when full and a reset with entries held are then checked with directed sequences.

// File: rtl/evict_drain_buffer.sv
module evict_drain_buffer #(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 64,
  localparam int DW = 8 * LINE_BYTES,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [DW-1:0]     enq_data,
  input  logic [LINE_BYTES-1:0] enq_mask,
  output logic              drn_valid,
  input  logic              drn_ready,
  output logic [ADDR_W-1:0] drn_addr,
  output logic [DW-1:0]     drn_data,
  output logic [LINE_BYTES-1:0] drn_mask,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_hit,
  output logic [DW-1:0]     lkp_data,
  output logic [LINE_BYTES-1:0] lkp_mask
);

  logic [ADDR_W-1:0]     addr_q [DEPTH];
  logic [DW-1:0]         data_q [DEPTH];
  logic [LINE_BYTES-1:0] mask_q [DEPTH];
  logic [PW-1:0]         rd_ptr, wr_ptr;
  logic [CW-1:0]         count;

  wire push = enq_valid && enq_ready;
  wire pop  = drn_valid && drn_ready;

  assign enq_ready = (count != CW'(DEPTH));
  assign drn_valid = (count != '0);
  assign drn_addr  = addr_q[rd_ptr];
  assign drn_data  = data_q[rd_ptr];
  assign drn_mask  = mask_q[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= enq_addr;
      data_q[wr_ptr] <= enq_data;
      mask_q[wr_ptr] <= enq_mask;
    end
  end

  always_comb begin
    lkp_data = '0;
    lkp_mask = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = rd_ptr + PW'(k);
      if (lkp_valid && (CW'(k) < count) && (addr_q[idx] == lkp_addr)) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (mask_q[idx][b]) begin
            lkp_data[b*8 +: 8] = data_q[idx][b*8 +: 8];
            lkp_mask[b]        = 1'b1;
          end
        end
      end
    end
  end

  assign lkp_hit = |lkp_mask;

endmodule

module evict_drain_buffer_chk #(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 64,
  localparam int DW = 8 * LINE_BYTES,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic              enq_ready,
  input logic              drn_valid,
  input logic              drn_ready,
  input logic [ADDR_W-1:0] drn_addr,
  input logic [DW-1:0]     drn_data,
  input logic [LINE_BYTES-1:0] drn_mask,
  input logic              lkp_valid,
  input logic              lkp_hit,
  input logic [LINE_BYTES-1:0] lkp_mask
);

  logic [CW-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else occ_q <= occ_q + CW'(enq_valid && enq_ready) - CW'(drn_valid && drn_ready);
  end

  assert_ready_tracks_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enq_ready == (occ_q != CW'(DEPTH)));

  assert_drain_valid_tracks_occ_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid == (occ_q != '0));

  assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr) && $stable(drn_data) && $stable(drn_mask)));

  assert_idle_lookup_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> (!lkp_hit && lkp_mask == '0));

  assert_empty_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) |-> !lkp_hit);

endmodule

bind evict_drain_buffer evict_drain_buffer_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .enq_valid(enq_valid), .enq_ready(enq_ready),
  .drn_valid(drn_valid), .drn_ready(drn_ready),
  .drn_addr(drn_addr), .drn_data(drn_data), .drn_mask(drn_mask),
  .lkp_valid(lkp_valid), .lkp_hit(lkp_hit), .lkp_mask(lkp_mask)
);

// File: tb/tb_evict_drain_buffer.sv
module tb_evict_drain_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int LB = 4;
  localparam int DW = 8 * LB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, drn_ready = 1'b0, lkp_valid = 1'b0;
  logic [AW-1:0] enq_addr = '0, lkp_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic [LB-1:0] enq_mask = '0;
  logic enq_ready, drn_valid, lkp_hit;
  logic [AW-1:0] drn_addr;
  logic [DW-1:0] drn_data, lkp_data;
  logic [LB-1:0] drn_mask, lkp_mask;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evict_drain_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_BYTES(LB)) dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
    .enq_data(enq_data), .enq_mask(enq_mask),
    .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_addr(drn_addr),
    .drn_data(drn_data), .drn_mask(drn_mask),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_hit(lkp_hit),
    .lkp_data(lkp_data), .lkp_mask(lkp_mask)
  );

  typedef struct packed {
    logic          ev;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    logic [LB-1:0] em;
    logic          dr;
    logic          lv;
    logic [AW-1:0] la;
    logic          xh;
    logic [DW-1:0] xd;
    logic [LB-1:0] xm;
    logic          xdv;
    logic [AW-1:0] xda;
    logic          xer;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R8: lookup of the line being accepted misses
    '{1'b1, 8'h10, 32'h11223344, 4'hf, 1'b0, 1'b1, 8'h10, 1'b0, 32'h0, 4'h0, 1'b0, 8'h00, 1'b1},
    // R2 R5: full-line hit, head now presented
    '{1'b1, 8'h20, 32'haabbccdd, 4'h3, 1'b0, 1'b1, 8'h10, 1'b1, 32'h11223344, 4'hf, 1'b1, 8'h10, 1'b1},
    // R6: partial entry, unmasked bytes read zero
    '{1'b1, 8'h20, 32'h55667788, 4'h6, 1'b0, 1'b1, 8'h20, 1'b1, 32'h0000ccdd, 4'h3, 1'b1, 8'h10, 1'b1},
    // R6: youngest wins on byte 1, bytes 0 and 2 merge
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 1'b1, 8'h20, 1'b1, 32'h006677dd, 4'h7, 1'b1, 8'h10, 1'b1},
    // R5: miss on absent line
    '{1'b1, 8'h30, 32'h01020304, 4'hf, 1'b0, 1'b1, 8'h40, 1'b0, 32'h0, 4'h0, 1'b1, 8'h10, 1'b1},
    // R3: full, offer refused
    '{1'b1, 8'h50, 32'hdeadbeef, 4'hf, 1'b0, 1'b1, 8'h50, 1'b0, 32'h0, 4'h0, 1'b1, 8'h10, 1'b0},
    // R7: lookup while its entry drains
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b1, 1'b1, 8'h10, 1'b1, 32'h11223344, 4'hf, 1'b1, 8'h10, 1'b0},
    // R3: refused line never stored
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 1'b1, 8'h50, 1'b0, 32'h0, 4'h0, 1'b1, 8'h20, 1'b1},
    // R9 R7: enqueue and drain together
    '{1'b1, 8'h10, 32'h99999999, 4'h1, 1'b1, 1'b1, 8'h20, 1'b1, 32'h006677dd, 4'h7, 1'b1, 8'h20, 1'b1},
    // R4 R6: only the later partial remains
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b1, 1'b1, 8'h20, 1'b1, 32'h00667700, 4'h6, 1'b1, 8'h20, 1'b1},
    // R4 R9: order kept across the simultaneous step
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b1, 1'b1, 8'h10, 1'b1, 32'h00000099, 4'h1, 1'b1, 8'h30, 1'b1},
    // R5: drained line no longer matches
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 1'b1, 8'h30, 1'b0, 32'h0, 4'h0, 1'b1, 8'h10, 1'b1},
    // R4: stalled head still there
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b1, 1'b1, 8'h10, 1'b1, 32'h00000099, 4'h1, 1'b1, 8'h10, 1'b1},
    // R1 R5: empty again
    '{1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 1'b1, 8'h10, 1'b0, 32'h0, 4'h0, 1'b0, 8'h00, 1'b1}
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    enq_valid = 1'b0; drn_ready = 1'b0; lkp_valid = 1'b0;
    enq_addr = '0; enq_data = '0; enq_mask = '0; lkp_addr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    @(negedge clk); @(negedge clk);
    #1;
    check("R1 reset drn_valid", 64'(drn_valid), 64'd0);
    check("R1 reset enq_ready", 64'(enq_ready), 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      enq_valid = VEC[i].ev; enq_addr = VEC[i].ea; enq_data = VEC[i].ed; enq_mask = VEC[i].em;
      drn_ready = VEC[i].dr; lkp_valid = VEC[i].lv; lkp_addr = VEC[i].la;
      #1;
      check($sformatf("row %0d R5 hit", i), 64'(lkp_hit), 64'(VEC[i].xh));
      check($sformatf("row %0d R6 data", i), 64'(lkp_data), 64'(VEC[i].xd));
      check($sformatf("row %0d R6 mask", i), 64'(lkp_mask), 64'(VEC[i].xm));
      check($sformatf("row %0d R4 drn_valid", i), 64'(drn_valid), 64'(VEC[i].xdv));
      if (VEC[i].xdv)
        check($sformatf("row %0d R4 drn_addr", i), 64'(drn_addr), 64'(VEC[i].xda));
      check($sformatf("row %0d R3 enq_ready", i), 64'(enq_ready), 64'(VEC[i].xer));
    end

    // R2 R4: fill, then drain in order with a stall before each take
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      idle_inputs();
      enq_valid = 1'b1; enq_addr = AW'(8'h60 + i);
      enq_data = 32'hc0de0000 + DW'(i); enq_mask = LB'(4'hf ^ i);
    end
    @(negedge clk);
    idle_inputs();
    // R3: full, offer with a drain in the same cycle is refused
    enq_valid = 1'b1; enq_addr = 8'h77; enq_data = 32'h77777777; enq_mask = 4'hf;
    drn_ready = 1'b1;
    #1;
    check("R3 ready low when full", 64'(enq_ready), 64'd0);
    check("R4 head addr", 64'(drn_addr), 64'h60);
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge clk);
      idle_inputs();
      #1;
      check("R4 stall valid", 64'(drn_valid), 64'd1);
      check("R4 order addr", 64'(drn_addr), 64'(8'h60 + i));
      @(negedge clk);
      drn_ready = 1'b1;
      #1;
      check("R4 stall hold addr", 64'(drn_addr), 64'(8'h60 + i));
      check("R4 order data", 64'(drn_data), 64'(32'hc0de0000 + i));
      check("R4 order mask", 64'(drn_mask), 64'(4'hf ^ i));
    end
    @(negedge clk);
    idle_inputs();
    #1;
    check("R3 refused entry absent", 64'(drn_valid), 64'd0);

    // R1: reset with entries held
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      idle_inputs();
      enq_valid = 1'b1; enq_addr = 8'h90; enq_data = 32'h12345678; enq_mask = 4'hf;
    end
    @(negedge clk);
    idle_inputs();
    lkp_valid = 1'b1; lkp_addr = 8'h90;
    #1;
    check("R5 hit before reset", 64'(lkp_hit), 64'd1);
    rst_n = 1'b0;
    #1;
    check("R1 reset drn_valid", 64'(drn_valid), 64'd0);
    check("R1 reset enq_ready", 64'(enq_ready), 64'd1);
    check("R1 reset lkp_hit", 64'(lkp_hit), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after reset lkp_hit", 64'(lkp_hit), 64'd0);
    check("R1 after reset drn_valid", 64'(drn_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule